// File: doc/BRIEF.md
# Floating-Point Status Single-Bit Write Unit

This block runs the two instructions that write one bit of the 32-bit floating-point status register. Each cycle it may take one 32-bit instruction word, qualified by a valid strobe. The word uses the fixed-width register format, and its bits are numbered from the most significant end. The block decodes the word and then sets or clears the one status bit that a 5-bit index selects. It keeps the register, presents the register for read-back, and drives a write port for condition-register field 1.

Two of the status bits are summaries that other logic derives. The unit never changes them, even when an instruction names them directly. The recording form of each instruction copies the four most significant status bits, as they stand after the write, into field 1. It does not compare a result with zero. Any instruction word the unit does not recognise leaves everything unchanged and raises a one-cycle decode-error pulse.

Top module: `fsr_bitop_unit`

## Requirements
- R1: A synchronous active-high reset clears `stat_q` to zero and holds `cr1_we` and `bad_op` low.
- R2: A valid word with primary opcode 63 in word bits 31:26 (LSB-0 numbering) and extended opcode 38 in bits 10:1 is a set. For example, 0xFC00004C sets index 0 with Rc=0. On the next clock edge a set drives the selected bit to 1 and leaves every other bit unchanged.
- R3: A valid word with primary opcode 63 and extended opcode 70 is a clear. On the next edge it drives the selected bit to 0 and leaves every other bit unchanged.
- R4: The bit index is word bits 25:21, and it counts from the most significant bit. Index k selects `stat_q[31-k]`, so index 0 is `stat_q[31]`.
- R5: Indices 1 and 2 are protected summary bits (`stat_q[30]` and `stat_q[29]`). A set or clear aimed at either one leaves `stat_q` unchanged.
- R6: The record flag is word bit 0. A legal set or clear with the record flag at 1 raises `cr1_we` for one cycle on the next edge, with `cr1_data` equal to `stat_q[31:28]` after the write. This also happens for a protected index.
- R7: A legal word with the record flag at 0 leaves `cr1_we` low.
- R8: Any other valid word has no effect on `stat_q` or `cr1_we`, and it raises `bad_op` for exactly one cycle on the next edge. A word presented with `insn_valid` low has no effect at all.
- R9: Word bits 20:11 (the two source fields) do not affect the result.
- R10: Instructions issued on consecutive cycles are applied in order, each one to the register value the previous one left.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| insn_valid | input | 1 | Marks `insn_word` as an instruction to execute this cycle |
| insn_word | input | 32 | Instruction word, most significant bit is bit 0 of the format |
| stat_q | output | 32 | Current status register value |
| cr1_we | output | 1 | Write enable for condition-register field 1 |
| cr1_data | output | 4 | Value for condition-register field 1 |
| bad_op | output | 1 | One-cycle pulse for an unrecognised valid word |

## Verification
Every result appears exactly one clock edge after the instruction is presented: the register value, the field-1 enable and data, and the decode-error pulse. The bench drives each instruction on a falling edge. It then waits for the next falling edge and compares all outputs there, after the single rising edge between the two. It keeps a model register of its own and updates it at the same point. Because of this, back-to-back instructions are checked cycle by cycle, with no skew.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int STAT_W = 32;
  localparam int IDX_W  = $clog2(STAT_W);
  localparam int WORD_W = 32;
  localparam logic [5:0] OPC_FP   = 6'd63;
  localparam logic [9:0] XO_SET   = 10'd38;
  localparam logic [9:0] XO_CLR   = 10'd70;
  localparam logic [STAT_W-1:0] PROT_MASK = 32'h6000_0000;

  typedef enum logic [1:0] {OP_NONE, OP_SET, OP_CLR, OP_BAD} bitop_e;

  typedef struct packed {
    bitop_e           op;
    logic [IDX_W-1:0] idx;
    logic             rec;
  } dec_t;

  // MSB-first index to LSB-0 bit position
  function automatic logic [IDX_W-1:0] idx_to_pos(input logic [IDX_W-1:0] idx);
    return IDX_W'(STAT_W - 1) - idx;
  endfunction
endpackage

// File: rtl/fsr_decode.sv
module fsr_decode
  import fsr_pkg::*;
(
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  output dec_t              dec
);
  logic [5:0] opc;
  logic [9:0] xo;

  assign opc = word[31:26];
  assign xo  = word[10:1];

  always_comb begin
    dec.idx = word[25:21];
    dec.rec = word[0];
    if (!valid)                          dec.op = OP_NONE;
    else if (opc == OPC_FP && xo == XO_SET) dec.op = OP_SET;
    else if (opc == OPC_FP && xo == XO_CLR) dec.op = OP_CLR;
    else                                 dec.op = OP_BAD;
  end
endmodule

// File: rtl/fsr_bit_update.sv
module fsr_bit_update
  import fsr_pkg::*;
#(
  parameter int W = STAT_W,
  parameter logic [W-1:0] PROT = PROT_MASK
) (
  input  logic [W-1:0]     cur,
  input  dec_t             dec,
  output logic [W-1:0]     nxt,
  output logic             prot_hit
);
  logic [IDX_W-1:0] pos;
  assign pos = idx_to_pos(dec.idx);
  assign prot_hit = PROT[pos];

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic sel;
    assign sel = (pos == IDX_W'(b)) && !PROT[b];
    always_comb begin
      nxt[b] = cur[b];
      if (sel && dec.op == OP_SET) nxt[b] = 1'b1;
      if (sel && dec.op == OP_CLR) nxt[b] = 1'b0;
    end
  end
endmodule

// File: rtl/fsr_bitop_unit.sv
module fsr_bitop_unit
  import fsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_valid,
  input  logic [WORD_W-1:0] insn_word,
  output logic [STAT_W-1:0] stat_q,
  output logic              cr1_we,
  output logic [3:0]        cr1_data,
  output logic              bad_op
);
  dec_t              dec;
  logic [STAT_W-1:0] stat_nxt;
  logic              prot_hit;
  logic              legal_ev;
  logic              rec_ev;

  fsr_decode u_dec (.valid(insn_valid), .word(insn_word), .dec(dec));

  fsr_bit_update u_upd (
    .cur(stat_q), .dec(dec), .nxt(stat_nxt), .prot_hit(prot_hit)
  );

  assign legal_ev = (dec.op == OP_SET) || (dec.op == OP_CLR);
  assign rec_ev   = legal_ev && dec.rec;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q   <= '0;
      cr1_we   <= 1'b0;
      cr1_data <= '0;
      bad_op   <= 1'b0;
    end else begin
      stat_q <= stat_nxt;
      cr1_we <= rec_ev;
      bad_op <= (dec.op == OP_BAD);
      if (rec_ev) cr1_data <= stat_nxt[STAT_W-1 -: 4];
    end
  end
endmodule

// File: rtl/fsr_bitop_chk.sv
module fsr_bitop_chk (
  input logic        clk,
  input logic        rst,
  input logic        insn_valid,
  input logic [31:0] insn_word,
  input logic [31:0] stat_q,
  input logic        cr1_we,
  input logic [3:0]  cr1_data,
  input logic        bad_op,
  input logic        prot_hit
);
  logic is_fp, is_set, is_clr, ok_idx;
  assign is_fp  = insn_valid && insn_word[31:26] == 6'd63;
  assign is_set = is_fp && insn_word[10:1] == 10'd38;
  assign is_clr = is_fp && insn_word[10:1] == 10'd70;
  assign ok_idx = insn_word[25:21] != 5'd1 && insn_word[25:21] != 5'd2;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (stat_q == 32'd0 && !cr1_we && !bad_op));

  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    (is_set && ok_idx) |=> stat_q[~$past(insn_word[25:21])]);

  p_clr_r3: assert property (@(posedge clk) disable iff (rst)
    (is_clr && ok_idx) |=> !stat_q[~$past(insn_word[25:21])]);

  p_prot_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(stat_q[30:29]));

  p_prot_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (prot_hit && (is_set || is_clr)) |=> $stable(stat_q));

  p_cr1_r6: assert property (@(posedge clk) disable iff (rst)
    cr1_we |-> cr1_data == stat_q[31:28]);

  p_norec_r7: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && !insn_word[0]) |=> !cr1_we);

  p_bad_r8: assert property (@(posedge clk) disable iff (rst)
    bad_op |-> (!cr1_we && stat_q == $past(stat_q)));

  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !insn_valid |=> (!bad_op && !cr1_we && $stable(stat_q)));
endmodule

bind fsr_bitop_unit fsr_bitop_chk u_chk (
  .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_word(insn_word),
  .stat_q(stat_q), .cr1_we(cr1_we), .cr1_data(cr1_data), .bad_op(bad_op),
  .prot_hit(prot_hit)
);

// File: tb/fsr_bitop_unit_tb.sv
`timescale 1ns/1ps
module fsr_bitop_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        insn_valid;
  logic [31:0] insn_word;
  logic [31:0] stat_q;
  logic        cr1_we;
  logic [3:0]  cr1_data;
  logic        bad_op;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] model;

  always #2 clk = ~clk;

  fsr_bitop_unit u_dut (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_word(insn_word),
    .stat_q(stat_q), .cr1_we(cr1_we), .cr1_data(cr1_data), .bad_op(bad_op)
  );

  function automatic logic [31:0] mk(int xo, int idx, bit rc, int ab);
    return (32'd63 << 26) | ((idx & 31) << 21) | ((ab & 10'h3ff) << 11)
           | ((xo & 10'h3ff) << 1) | rc;
  endfunction

  // 0 idle, 1 set, 2 clear, 3 illegal
  function automatic int kind(bit v, logic [31:0] w);
    int xo;
    xo = (w >> 1) & 32'h3ff;
    if (!v) return 0;
    if ((w >> 26) != 63) return 3;
    if (xo == 38) return 1;
    if (xo == 70) return 2;
    return 3;
  endfunction

  function automatic logic [31:0] apply(logic [31:0] r, bit v, logic [31:0] w);
    int k, idx;
    logic [31:0] m;
    k = kind(v, w);
    idx = (w >> 21) & 31;
    m = 32'h8000_0000 >> idx;
    if (idx == 1 || idx == 2) return r;
    if (k == 1) return r | m;
    if (k == 2) return r & ~m;
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, check at the following falling edge
  task automatic issue(bit v, logic [31:0] w, string tag);
    int k;
    bit rc_exp;
    k = kind(v, w);
    insn_valid = v;
    insn_word  = w;
    model = apply(model, v, w);
    rc_exp = (k == 1 || k == 2) && w[0];
    @(negedge clk);
    chk(stat_q == model, tag, stat_q, model);
    chk(cr1_we == rc_exp, rc_exp ? "R6 we" : "R7 we", {31'd0, cr1_we}, {31'd0, rc_exp});
    if (rc_exp) chk(cr1_data == model[31:28], "R6 data", {28'd0, cr1_data}, {28'd0, model[31:28]});
    chk(bad_op == (k == 3), "R8 bad_op", {31'd0, bad_op}, {31'd0, k == 3});
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed);
    rst = 1'b1; insn_valid = 1'b0; insn_word = '0; model = '0;
    repeat (3) @(negedge clk);
    chk(stat_q == 0 && !cr1_we && !bad_op, "R1 reset", stat_q, 0);
    rst = 1'b0;

    issue(1, 32'hFC00004C, "R2 set FX");
    chk(stat_q[31] == 1'b1, "R4 index0 is MSB", stat_q, 32'h8000_0000);
    issue(1, mk(38, 3, 1, 0), "R2 set OX rec");
    chk(cr1_data == 4'b1001, "R6 nibble", cr1_data, 4'b1001);
    issue(1, mk(38, 1, 1, 0), "R5 set idx1");
    issue(1, mk(38, 2, 0, 0), "R5 set idx2");
    issue(1, mk(70, 1, 1, 0), "R5 clr idx1");
    chk(cr1_we && cr1_data == 4'b1001, "R6 protected rec", cr1_data, 4'b1001);
    issue(1, mk(38, 31, 0, 10'h3ff), "R9 set idx31 with A/B");
    chk(stat_q[0] == 1'b1, "R4 index31 is LSB", stat_q, model);
    issue(1, mk(38, 10, 0, 0), "R10 set idx10");
    issue(1, mk(70, 10, 0, 0), "R10 clr idx10");
    chk(stat_q[21] == 1'b0, "R10 order", stat_q, model);
    issue(1, mk(70, 0, 1, 0), "R3 clr FX rec");
    chk(cr1_data == 4'b0001, "R3 nibble", cr1_data, 4'b0001);
    issue(1, mk(39, 5, 1, 0), "R8 bad xo");
    issue(1, 32'h7C00004D, "R8 bad opcode");
    issue(0, mk(38, 7, 1, 0), "R8 idle");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] w;
      int sel, k;
      sel = $urandom_range(0, 9);
      w = mk(sel < 4 ? 38 : (sel < 8 ? 70 : $urandom_range(0, 1023)),
             $urandom_range(0, 31), 1'($urandom_range(0, 1)), $urandom_range(0, 1023));
      if (sel == 9) w[31:26] = 6'($urandom_range(0, 62));
      k = kind(1, w);
      issue($urandom_range(0, 9) != 0, w,
            k == 1 ? "R2 rand" : (k == 2 ? "R3 rand" : "R8 rand"));
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule